// File: doc/BRIEF.md
# Execute-Stage ALU with Condition Evaluation

This block is the execute stage of a single-cycle processor. A combinational ALU combines two 64-bit operands under one of four operations and drives the result straight out in the same cycle. A two-bit condition-code register records whether the last flag-writing result was zero and whether it was negative; it is written on a rising clock edge only when the caller asks for it.

Alongside the ALU, a condition evaluator turns a three-bit condition code of the current instruction into a one-bit verdict. The verdict is always taken from the flags already stored, so an instruction that both tests and writes the flags sees the old ones. For a conditional move, a false verdict replaces the destination register number with the reserved "no register" value 0xF, so the later write-back writes nothing; all other instructions pass the register number through unchanged.

Top module: `exec_cc_unit`

## Requirements
- R1: `alu_op` selects the operation: 0 = add (b + a), 1 = subtract (b − a), 2 = bitwise AND, 3 = bitwise XOR; results wrap modulo 2^64.
- R2: `val_e` is combinational: it reflects the current operands and operation in the same cycle, with no register on the path.
- R3: On a rising clock edge with `cc_we` high, `flag_z` becomes 1 exactly when `val_e` is zero and `flag_s` becomes bit 63 of `val_e`.
- R4: On a rising clock edge with `cc_we` low, `flag_z` and `flag_s` keep their values whatever the ALU computes.
- R5: While `rst_n` is low the flags are `flag_z` = 1, `flag_s` = 0.
- R6: `cond_ok` is computed from the stored flags only; flags written by the current instruction affect it from the next cycle on.
- R7: `cond_fn` encoding: 0 always → 1; 1 less-or-equal → S|Z; 2 less → S; 3 equal → Z; 4 not-equal → !Z; 5 greater-or-equal → !S; 6 greater → !S & !Z.
- R8: `cond_fn` = 7 is a never condition: `cond_ok` is 0 for every flag state.
- R9: With `is_cmov` high, `dst_e` equals `rb_idx` when `cond_ok` is 1 and 0xF when it is 0; with `is_cmov` low, `dst_e` equals `rb_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_a | input | 64 | First ALU operand (subtrahend for subtract) |
| alu_b | input | 64 | Second ALU operand |
| alu_op | input | 2 | ALU operation select |
| cc_we | input | 1 | Condition-code write enable |
| cond_fn | input | 3 | Condition selector of the current instruction |
| is_cmov | input | 1 | Current instruction is a conditional move |
| rb_idx | input | 4 | Destination register number from the instruction |
| val_e | output | 64 | ALU result |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| cond_ok | output | 1 | Condition verdict |
| dst_e | output | 4 | Destination register number after squashing |

## Verification
The properties assume that operands, operation, condition selector and write enable are steady around each rising edge, so the value sampled at the edge is the one that produced the stored flags. The stimulus changes inputs only on the falling edge and holds them through the following rising edge. They also assume `rb_idx` may itself be 0xF, which is legal and simply means the pass-through case already writes nothing; the stimulus uses ordinary register numbers when it probes squashing so the two cases stay distinguishable.

// File: rtl/exec_cc_pkg.sv
package exec_cc_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } alu_op_e;

    typedef enum logic [2:0] {
        CF_ALWAYS = 3'd0,
        CF_LE     = 3'd1,
        CF_LT     = 3'd2,
        CF_EQ     = 3'd3,
        CF_NE     = 3'd4,
        CF_GE     = 3'd5,
        CF_GT     = 3'd6,
        CF_NEVER  = 3'd7
    } cond_fn_e;

    typedef struct packed {
        logic z;
        logic s;
    } flags_t;

    localparam flags_t FLAGS_RST = '{z: 1'b1, s: 1'b0};

endpackage

// File: rtl/exec_alu.sv
module exec_alu
    import exec_cc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        op_sel,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        unique case (alu_op_e'(op_sel))
            OP_ADD:  result = opnd_b + opnd_a;
            OP_SUB:  result = opnd_b - opnd_a;
            OP_AND:  result = opnd_b & opnd_a;
            OP_XOR:  result = opnd_b ^ opnd_a;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/exec_cond_eval.sv
module exec_cond_eval
    import exec_cc_pkg::*;
(
    input  logic [2:0] fn_sel,
    input  flags_t     flags,
    output logic       verdict
);
    always_comb begin
        unique case (cond_fn_e'(fn_sel))
            CF_ALWAYS: verdict = 1'b1;
            CF_LE:     verdict = flags.s | flags.z;
            CF_LT:     verdict = flags.s;
            CF_EQ:     verdict = flags.z;
            CF_NE:     verdict = ~flags.z;
            CF_GE:     verdict = ~flags.s;
            CF_GT:     verdict = ~flags.s & ~flags.z;
            CF_NEVER:  verdict = 1'b0;
            default:   verdict = 1'b0;
        endcase
    end
endmodule

// File: rtl/exec_cc_unit.sv
module exec_cc_unit
    import exec_cc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int REG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] alu_a,
    input  logic [DATA_W-1:0] alu_b,
    input  logic [1:0]        alu_op,
    input  logic              cc_we,
    input  logic [2:0]        cond_fn,
    input  logic              is_cmov,
    input  logic [REG_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] val_e,
    output logic              flag_z,
    output logic              flag_s,
    output logic              cond_ok,
    output logic [REG_W-1:0]  dst_e
);
    localparam logic [REG_W-1:0] REG_NONE = {REG_W{1'b1}};
    localparam int               SIGN_BIT = DATA_W - 1;

    flags_t             flags_d, flags_q;
    logic [DATA_W-1:0]  alu_res;
    logic               verdict;

    exec_alu #(.DATA_W(DATA_W)) u_alu (
        .opnd_a (alu_a),
        .opnd_b (alu_b),
        .op_sel (alu_op),
        .result (alu_res)
    );

    // verdict sees only the registered flags, never flags_d
    exec_cond_eval u_cond (
        .fn_sel  (cond_fn),
        .flags   (flags_q),
        .verdict (verdict)
    );

    always_comb begin
        flags_d = flags_q;
        if (cc_we) begin
            flags_d.z = (alu_res == '0);
            flags_d.s = alu_res[SIGN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= FLAGS_RST;
        else        flags_q <= flags_d;
    end

    assign val_e   = alu_res;
    assign flag_z  = flags_q.z;
    assign flag_s  = flags_q.s;
    assign cond_ok = verdict;
    assign dst_e   = (is_cmov && !verdict) ? REG_NONE : rb_idx;
endmodule

// File: rtl/exec_cc_chk.sv
module exec_cc_chk #(
    parameter int DATA_W = 64,
    parameter int REG_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] alu_a,
    input logic [DATA_W-1:0] alu_b,
    input logic [1:0]        alu_op,
    input logic              cc_we,
    input logic [2:0]        cond_fn,
    input logic              is_cmov,
    input logic [REG_W-1:0]  rb_idx,
    input logic [DATA_W-1:0] val_e,
    input logic              flag_z,
    input logic              flag_s,
    input logic              cond_ok,
    input logic [REG_W-1:0]  dst_e
);
    p_sub_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 2'd1) |-> (val_e == alu_b - alu_a));

    p_zero_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |=> (flag_z == ($past(val_e) == '0)));

    p_sign_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |=> (flag_s == $past(val_e[DATA_W-1])));

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_we |=> $stable({flag_z, flag_s}));

    p_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn == 3'd0) |-> cond_ok);

    p_eq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn == 3'd3) |-> (cond_ok == flag_z));

    p_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fn == 3'd7) |-> !cond_ok);

    p_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmov && !cond_ok) |-> (dst_e == {REG_W{1'b1}}));

    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_cmov || cond_ok) |-> (dst_e == rb_idx));
endmodule

bind exec_cc_unit exec_cc_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alu_a(alu_a), .alu_b(alu_b), .alu_op(alu_op),
    .cc_we(cc_we), .cond_fn(cond_fn), .is_cmov(is_cmov), .rb_idx(rb_idx),
    .val_e(val_e), .flag_z(flag_z), .flag_s(flag_s), .cond_ok(cond_ok),
    .dst_e(dst_e)
);

// File: tb/exec_cc_unit_bench.sv
module exec_cc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] alu_a = '0, alu_b = '0;
    logic [1:0]  alu_op = '0;
    logic        cc_we = 1'b0;
    logic [2:0]  cond_fn = '0;
    logic        is_cmov = 1'b0;
    logic [3:0]  rb_idx = '0;
    logic [63:0] val_e;
    logic        flag_z, flag_s, cond_ok;
    logic [3:0]  dst_e;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    exec_cc_unit u_exec_cc_unit (
        .clk(clk), .rst_n(rst_n), .alu_a(alu_a), .alu_b(alu_b), .alu_op(alu_op),
        .cc_we(cc_we), .cond_fn(cond_fn), .is_cmov(is_cmov), .rb_idx(rb_idx),
        .val_e(val_e), .flag_z(flag_z), .flag_s(flag_s), .cond_ok(cond_ok),
        .dst_e(dst_e)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] res;
        logic        z;
        logic        s;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 64'd5, 64'd7, 64'd12, 1'b0, 1'b0},
        '{2'd1, 64'd5, 64'd7, 64'd2, 1'b0, 1'b0},
        '{2'd1, 64'd7, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1},
        '{2'd2, 64'hF0F0, 64'hFF00, 64'hF000, 1'b0, 1'b0},
        '{2'd3, 64'hF0F0, 64'hFF00, 64'h0FF0, 1'b0, 1'b0},
        '{2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b1, 1'b0},
        '{2'd1, 64'd3, 64'd3, 64'd0, 1'b1, 1'b0},
        '{2'd3, 64'h8000_0000_0000_0000, 64'd0, 64'h8000_0000_0000_0000, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic ref_cond(input logic [2:0] fn, input logic z, input logic s);
        case (fn)
            3'd0: return 1'b1;
            3'd1: return s | z;
            3'd2: return s;
            3'd3: return z;
            3'd4: return !z;
            3'd5: return !s;
            3'd6: return !s && !z;
            default: return 1'b0;
        endcase
    endfunction

    // load flags through the ALU, then leave them alone
    task automatic load_flags(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        alu_op = op; alu_a = a; alu_b = b; cc_we = 1'b1;
        @(negedge clk);
        cc_we = 1'b0;
    endtask

    task automatic sweep_conds(input logic z, input logic s);
        for (int f = 0; f < 8; f++) begin
            cond_fn = 3'(f);
            #1;
            if (f == 7) check("R8 never", {63'd0, cond_ok}, 64'd0);
            else        check("R7 cond",  {63'd0, cond_ok}, {63'd0, ref_cond(3'(f), z, s)});
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R5 reset z", {63'd0, flag_z}, 64'd1);
        check("R5 reset s", {63'd0, flag_s}, 64'd0);
        rst_n = 1'b1;

        // table walk: R1, R2 then R3
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            alu_op = VECS[i].op; alu_a = VECS[i].a; alu_b = VECS[i].b; cc_we = 1'b1;
            #1;
            check("R1 R2 val_e", val_e, VECS[i].res);
            @(negedge clk);
            check("R3 zero flag", {63'd0, flag_z}, {63'd0, VECS[i].z});
            check("R3 sign flag", {63'd0, flag_s}, {63'd0, VECS[i].s});
        end
        cc_we = 1'b0;

        // R4: zero result with write disabled, flags stay z=0 s=1
        load_flags(2'd1, 64'd9, 64'd4);
        @(negedge clk);
        alu_op = 2'd3; alu_a = 64'd6; alu_b = 64'd6; cc_we = 1'b0;
        @(negedge clk);
        check("R4 hold z", {63'd0, flag_z}, 64'd0);
        check("R4 hold s", {63'd0, flag_s}, 64'd1);

        // R7/R8 across three flag states
        sweep_conds(1'b0, 1'b1);
        load_flags(2'd0, 64'd1, 64'd2);
        sweep_conds(1'b0, 1'b0);
        load_flags(2'd2, 64'hF0, 64'h0F);
        sweep_conds(1'b1, 1'b0);

        // R6: flags z=1 now; write a negative result and test EQ in the same cycle
        @(negedge clk);
        cond_fn = 3'd3; alu_op = 2'd1; alu_a = 64'd2; alu_b = 64'd1; cc_we = 1'b1;
        #1;
        check("R6 old flags", {63'd0, cond_ok}, 64'd1);
        @(negedge clk);
        cc_we = 1'b0;
        #1;
        check("R6 new flags", {63'd0, cond_ok}, 64'd0);

        // R9: flags z=0 s=1; LT true, GE false
        is_cmov = 1'b1; rb_idx = 4'd3; cond_fn = 3'd2;
        #1;
        check("R9 cmov taken", {60'd0, dst_e}, 64'd3);
        cond_fn = 3'd5;
        #1;
        check("R9 cmov squashed", {60'd0, dst_e}, 64'hF);
        is_cmov = 1'b0; rb_idx = 4'd6;
        #1;
        check("R9 non-cmov pass", {60'd0, dst_e}, 64'd6);

        // R5 again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R5 async reset z", {63'd0, flag_z}, 64'd1);
        check("R5 async reset s", {63'd0, flag_s}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule